// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block lets a synchronous on-chip requester use an external asynchronous static RAM of 64K words by 16 bits. A request carries a word address, write data, a two-bit lane mask and a direction flag. The block accepts it with a valid/ready handshake and replays it on the memory pins as a sequence of phases timed in clock cycles. The memory has active-low chip, write, output and per-byte enables. Its bidirectional data bus appears here as three signals: an output value, an output enable and an input value.

A read keeps chip, output and the selected lane enables low for `RD_CYCLES` clocks. The data is then captured and returned with a one-cycle valid strobe. Then `TURN_CYCLES` idle clocks let the memory release the bus. A write presents address, data and lanes for one cycle, pulses the write strobe low for `WR_PULSE_CYCLES` clocks, and holds everything for one more cycle. The state machine has six states: IDLE, RD_ACT, RD_TURN, WR_SETUP, WR_PULSE and WR_HOLD. Its transitions are:

- IDLE to RD_ACT on an accepted read.
- IDLE to WR_SETUP on an accepted write.
- RD_ACT to RD_TURN when the phase timer expires.
- RD_TURN to IDLE when the phase timer expires.
- WR_SETUP to WR_PULSE after one cycle.
- WR_PULSE to WR_HOLD when the phase timer expires.
- WR_HOLD to IDLE after one cycle.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is applied and after it is released, req_ready is 1, every memory strobe is high, mem_dq_oe is 0 and rsp_valid is 0.
- R2: req_ready is 1 only in IDLE, where all strobes are high and the data driver is off. A request is taken on a clock edge with req_valid and req_ready both 1. After it, req_ready stays 0 for RD_CYCLES+TURN_CYCLES cycles after a read, and WR_PULSE_CYCLES+2 cycles after a write.
- R3: During the RD_CYCLES cycles after a read is taken, mem_ce_n and mem_oe_n are 0 and mem_we_n is 1. mem_dq_oe is 0. mem_lb_n is the inverse of req_mask bit 0 (data bits 7..0), and mem_ub_n is the inverse of req_mask bit 1 (data bits 15..8).
- R4: In the cycle after the read phase, rsp_valid is 1 for exactly one cycle. rsp_rdata holds mem_dq_in as sampled at the end of the read phase, with each lane whose mask bit is 0 forced to zero.
- R5: After mem_oe_n rises, mem_dq_oe stays 0 for at least TURN_CYCLES cycles.
- R6: In the first cycle of a write, mem_ce_n is 0, mem_we_n is 1, mem_dq_oe is 1, and the lane enables follow the mask as in R3. mem_dq_out carries the request data.
- R7: mem_we_n is 0 for exactly WR_PULSE_CYCLES consecutive cycles per write, always with mem_ce_n 0, mem_oe_n 1 and mem_dq_oe 1.
- R8: In the cycle after mem_we_n rises, mem_ce_n stays 0, mem_dq_oe stays 1, and address, data and lanes are unchanged.
- R9: A mask of 00 leaves both lane enables high, so a write changes no memory contents and a read returns zero.
- R10: mem_dq_oe is never 1 while mem_oe_n is 0.
- R11: mem_addr equals the request address and stays constant from acceptance to the end of the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Lane select, bit 0 = bits 7..0 |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read data, unselected lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low lane enable, active low |
| mem_ub_n | output | 1 | High lane enable, active low |
| mem_dq_out | output | DATA_W | Value to drive on the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | DATA_W | Value sampled from the data bus |

## Verification
Let edge A be the clock edge that takes a request. For a read, the read strobes are due in the RD_CYCLES cycles after A. The response is due in cycle RD_CYCLES+1 after A, and ready returns after RD_CYCLES+TURN_CYCLES busy cycles. For a write, the setup cycle is cycle 1 after A and the write pulse spans cycles 2 to WR_PULSE_CYCLES+1. The hold cycle is WR_PULSE_CYCLES+2, and ready returns in the cycle after it. The bench drives inputs and samples outputs only on falling edges, and it counts falling edges from A to reach the exact cycle of each expected value. A memory model in the bench acts on the strobes, and a shadow array computed from the lane masks gives every expected read word. The bench sweeps 16 addresses, all four masks and two data passes.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_ACT,
        S_RD_TURN,
        S_WR_SETUP,
        S_WR_PULSE,
        S_WR_HOLD
    } ctl_state_t;
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sram_lane_mask.sv
module sram_lane_mask #(
    parameter int LANES = 2
) (
    input  logic [LANES*8-1:0] din,
    input  logic [LANES-1:0]   sel,
    output logic [LANES*8-1:0] dout
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[g*8 +: 8] = sel[g] ? din[g*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W          = 16,
    parameter int DATA_W          = 16,
    parameter int RD_CYCLES       = 3,
    parameter int WR_PULSE_CYCLES = 2,
    parameter int TURN_CYCLES     = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_mask,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_ce_n,
    output logic                mem_we_n,
    output logic                mem_oe_n,
    output logic                mem_lb_n,
    output logic                mem_ub_n,
    output logic [DATA_W-1:0]   mem_dq_out,
    output logic                mem_dq_oe,
    input  logic [DATA_W-1:0]   mem_dq_in
);
    localparam int LANES = DATA_W / 8;
    localparam int MAXC  = (RD_CYCLES > WR_PULSE_CYCLES)
                         ? ((RD_CYCLES > TURN_CYCLES) ? RD_CYCLES : TURN_CYCLES)
                         : ((WR_PULSE_CYCLES > TURN_CYCLES) ? WR_PULSE_CYCLES : TURN_CYCLES);
    localparam int CW    = $clog2(MAXC + 1);

    ctl_state_t        state, nxt;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q;
    logic [DATA_W-1:0] masked_in;
    logic              t_load, t_done;
    logic [CW-1:0]     t_val;

    sram_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    sram_lane_mask #(.LANES(LANES)) u_mask (
        .din  (mem_dq_in),
        .sel  (mask_q),
        .dout (masked_in)
    );

    // Next state and phase timer loads
    always_comb begin
        nxt    = state;
        t_load = 1'b0;
        t_val  = '0;
        unique case (state)
            S_IDLE: begin
                if (req_valid) begin
                    if (req_write) begin
                        nxt = S_WR_SETUP;
                    end else begin
                        nxt    = S_RD_ACT;
                        t_load = 1'b1;
                        t_val  = CW'(RD_CYCLES - 1);
                    end
                end
            end
            S_RD_ACT: begin
                if (t_done) begin
                    nxt    = S_RD_TURN;
                    t_load = 1'b1;
                    t_val  = CW'(TURN_CYCLES - 1);
                end
            end
            S_RD_TURN:  if (t_done) nxt = S_IDLE;
            S_WR_SETUP: begin
                nxt    = S_WR_PULSE;
                t_load = 1'b1;
                t_val  = CW'(WR_PULSE_CYCLES - 1);
            end
            S_WR_PULSE: if (t_done) nxt = S_WR_HOLD;
            S_WR_HOLD:  nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    // State register, request capture, read response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            addr_q    <= '0;
            wdata_q   <= '0;
            mask_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            state     <= nxt;
            rsp_valid <= 1'b0;
            if (state == S_IDLE && req_valid) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                mask_q  <= req_mask;
            end
            if (state == S_RD_ACT && t_done) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= masked_in;
            end
        end
    end

    // Pin strobes decoded from the state
    always_comb begin
        req_ready = 1'b0;
        mem_ce_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_lb_n  = 1'b1;
        mem_ub_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state)
            S_IDLE:    req_ready = 1'b1;
            S_RD_ACT: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
                mem_lb_n = ~mask_q[0];
                mem_ub_n = ~mask_q[1];
            end
            S_RD_TURN: ;
            S_WR_SETUP, S_WR_HOLD: begin
                mem_ce_n  = 1'b0;
                mem_lb_n  = ~mask_q[0];
                mem_ub_n  = ~mask_q[1];
                mem_dq_oe = 1'b1;
            end
            S_WR_PULSE: begin
                mem_ce_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_lb_n  = ~mask_q[0];
                mem_ub_n  = ~mask_q[1];
                mem_dq_oe = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int ADDR_W      = 16,
    parameter int TURN_CYCLES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);
    int since_oe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            since_oe <= TURN_CYCLES;
        else if (!mem_oe_n)
            since_oe <= 0;
        else if (since_oe < TURN_CYCLES)
            since_oe <= since_oe + 1;
    end

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (since_oe >= TURN_CYCLES));

    p_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(mem_dq_oe) && !$past(mem_ce_n) && $stable(mem_addr)));

    p_we_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && $stable(mem_addr)));

    p_no_contention_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    p_addr_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready)) |-> $stable(mem_addr));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
    .ADDR_W      (ADDR_W),
    .TURN_CYCLES (TURN_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_test.sv
`timescale 1ns/1ps
module sram_lane_ctrl_test;
    localparam int RD = 3;
    localparam int WR = 2;
    localparam int TN = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [15:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sram_lane_ctrl #(
        .RD_CYCLES(RD), .WR_PULSE_CYCLES(WR), .TURN_CYCLES(TN)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Memory model: 16 words, addressed by the low address bits
    logic [15:0] ram    [0:15];
    logic [15:0] shadow [0:15];
    logic [15:0] wval;

    assign wval = mem_dq_oe ? mem_dq_out : 16'h0BAD;
    always @(negedge clk) begin
        if (!mem_ce_n && !mem_we_n) begin
            if (!mem_lb_n) ram[mem_addr[3:0]][7:0]  <= wval[7:0];
            if (!mem_ub_n) ram[mem_addr[3:0]][15:8] <= wval[15:8];
        end
    end

    always_comb begin
        mem_dq_in = 16'hA5A5;
        if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
            if (!mem_lb_n) mem_dq_in[7:0]  = ram[mem_addr[3:0]][7:0];
            if (!mem_ub_n) mem_dq_in[15:8] = ram[mem_addr[3:0]][15:8];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input bit w, input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready in idle", {31'b0, req_ready}, 1);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0; req_addr = 16'hFFFF; req_wdata = 16'h0000; req_mask = 2'b00;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
        issue(1'b1, a, d, m);
        // cycle 1: setup
        chk(mem_we_n && !mem_ce_n && mem_dq_oe && mem_dq_out == d, "R6 setup", {mem_we_n, mem_ce_n, mem_dq_oe, 13'b0, mem_dq_out}, {3'b101, 13'b0, d});
        chk({mem_ub_n, mem_lb_n} == ~m, "R9 R6 lanes", {30'b0, mem_ub_n, mem_lb_n}, {30'b0, ~m});
        chk(mem_addr == a, "R11 address", {16'b0, mem_addr}, {16'b0, a});
        for (int i = 0; i < WR; i++) begin
            @(negedge clk);
            chk(!mem_we_n && mem_oe_n && mem_dq_oe && !mem_ce_n, "R7 pulse", {mem_we_n, mem_oe_n, mem_dq_oe, mem_ce_n}, 4'b0110);
        end
        @(negedge clk);
        chk(mem_we_n && !mem_ce_n && mem_dq_oe && mem_dq_out == d && {mem_ub_n, mem_lb_n} == ~m,
            "R8 hold", {mem_we_n, mem_ce_n, mem_dq_oe, mem_ub_n, mem_lb_n, 11'b0, mem_dq_out}, {3'b101, ~m, 11'b0, d});
        chk(req_ready == 1'b0, "R2 busy write", {31'b0, req_ready}, 0);
        if (m[0]) shadow[a[3:0]][7:0]  = d[7:0];
        if (m[1]) shadow[a[3:0]][15:8] = d[15:8];
    endtask

    task automatic do_read(input logic [15:0] a, input logic [1:0] m);
        logic [15:0] exp;
        exp = {m[1] ? shadow[a[3:0]][15:8] : 8'h00, m[0] ? shadow[a[3:0]][7:0] : 8'h00};
        issue(1'b0, a, 16'h0, m);
        for (int i = 0; i < RD; i++) begin
            chk(!mem_ce_n && !mem_oe_n && mem_we_n && !mem_dq_oe && {mem_ub_n, mem_lb_n} == ~m,
                "R3 R9 read strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, mem_ub_n, mem_lb_n}, {4'b0010, ~m});
            chk(rsp_valid == 1'b0, "R4 early", {31'b0, rsp_valid}, 0);
            @(negedge clk);
        end
        chk(rsp_valid == 1'b1 && rsp_rdata == exp, "R4 R9 response", {15'b0, rsp_valid, rsp_rdata}, {15'b0, 1'b1, exp});
        chk(mem_oe_n && !mem_dq_oe, "R5 turn", {mem_oe_n, mem_dq_oe}, 2'b10);
        for (int i = 1; i < TN; i++) begin
            @(negedge clk);
            chk(!rsp_valid && !mem_dq_oe && !req_ready, "R4 R5 R2 turn busy", {rsp_valid, mem_dq_oe, req_ready}, 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin ram[i] = 16'h0; shadow[i] = 16'h0; end
        repeat (3) @(negedge clk);
        chk(req_ready && mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe && !rsp_valid,
            "R1 in reset", {req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe, rsp_valid}, 8'hFC);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
            "R1 after reset", {req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}, 6'h3C);
        for (int pass = 0; pass < 2; pass++) begin
            for (int a = 0; a < 16; a++)
                for (int m = 0; m < 4; m++)
                    do_write(16'(a), 16'(16'h1357 * (a + 1) + 16'h0F0F * m + 16'h2222 * pass), 2'(m));
            for (int a = 0; a < 16; a++)
                for (int m = 0; m < 4; m++)
                    do_read(16'(a), 2'(m));
        end
        // read directly followed by write: bus turnaround
        do_read(16'h0005, 2'b11);
        do_write(16'h0005, 16'hBEEF, 2'b01);
        do_read(16'h0005, 2'b11);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule